// File: doc/BRIEF.md
# Synchronizing Frame Reader

This block is the controller end of a slow serial link on which one or more remote measurement units share a single data return line. The reader raises exactly one enable line to pick a unit, then toggles a common clock line and samples the data line once in each clock phase. Every level it drives is held for a settle interval, counted in clock cycles, that must be longer than the debounce filter set in the remote units. Two settle lengths are available: a short one and a long one.

A frame is one synchronism bit followed by 16-bit channel words, most significant bit first, for either two or four channels. The synchronism bit follows the clock level, so it reads high in the high phase and low in the low phase. A data bit changes only on the rising clock edge, so it reads the same in both phases. The reader hunts for the synchronism pattern and assembles the words. It presents each complete frame with a one-cycle strobe and the unit index. It also treats a data bit whose two phase samples disagree as a loss of framing. In that case it drops the enable line, waits, and starts over, and it bumps a saturating error counter.

While `run` is high the reader keeps reading frames back to back from the unit latched when it left idle. When `run` is low, it stops at the next frame or synchronism boundary and returns to idle.

Top module: `sync_frame_reader`

## Requirements
- R1: After reset all enable lines are low, the clock line is low, no frame strobe or error pulse is given, and the error count is 0.
- R2: At most one enable line is high at a time, and it is bit `dev_sel` of `en_o`, latched when the reader leaves idle.
- R3: Every clock line level is held for exactly SHORT_CYC cycles when `slow_filt` was 0 at start, or LONG_CYC cycles when it was 1. The enable line is also held for that long before the first clock rise and after an abort.
- R4: The enable lines change only while the clock line is low, and the clock line is high only while an enable line is high.
- R5: A synchronism bit is accepted only when the data line reads 1 at the end of a high phase and then 0 at the end of the following low phase. Any other pattern repeats the attempt without counting an error. A misaligned unit is thereby picked up at its next synchronism bit.
- R6: Data bits are taken MSB first. The first channel sent appears on `frame_data[15:0]`, the second on `[31:16]`, and so on. With `wide_mode` = 0, two channels are read and `frame_data[63:32]` is zero; with `wide_mode` = 1, four channels are read.
- R7: After the last bit of the last channel, the reader looks for a new synchronism bit and continues with the next frame without dropping the enable line.
- R8: When the high-phase and low-phase samples of a data bit differ, `sync_err` pulses for one cycle. The frame is discarded, and in the same cycle the enable line goes low. The reader then waits one settle interval, raises the enable line again, waits another settle interval, and hunts for synchronism.
- R9: `err_cnt` rises by one on each `sync_err` pulse and stays at its all-ones value once it gets there.
- R10: `frame_vld` is high for a single cycle per completed frame, with `frame_data` and `frame_dev` valid in that cycle.
- R11: With `run` low, the reader finishes at most the frame in progress, then drops the enable line and returns to idle with the clock line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Keep reading frames while high |
| dev_sel | input | DEV_W | Unit to read, latched when leaving idle |
| wide_mode | input | 1 | 0: two channels, 1: four channels |
| slow_filt | input | 1 | 0: short settle interval, 1: long settle interval |
| sdata_i | input | 1 | Shared serial data return line |
| en_o | output | NUM_DEV | One-hot unit enable lines |
| sclk_o | output | 1 | Common serial clock line |
| frame_vld | output | 1 | One-cycle strobe for a completed frame |
| frame_dev | output | DEV_W | Index of the unit being read |
| frame_data | output | NCH_MAX*WORD_W | Channel words, first channel in the low word |
| sync_err | output | 1 | One-cycle pulse on an unstable data bit |
| err_cnt | output | ERR_W | Saturating count of unstable-bit errors |

## Verification
Frames are exercised with random words and with directed extreme words (sign bit alone, largest positive, all ones, one). This exposes bit-order and channel-placement mistakes in both channel counts. Each unit index is exercised with both settle lengths, which separates correct enable decoding and hold timing from a fixed default. A unit that starts mid-frame shows that the synchronism hunt rejects stable data bits and picks up the next real synchronism bit without counting errors. Data bits flipped between phases, repeated past the counter range, separate the abort-and-restart path and counter saturation from an ordinary resync.

// File: rtl/sync_frame_reader.sv
module sync_frame_reader #(
  parameter int NUM_DEV   = 4,
  parameter int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int WORD_W    = 16,
  parameter int NCH_MIN   = 2,
  parameter int NCH_MAX   = 4,
  parameter int SHORT_CYC = 120000,
  parameter int LONG_CYC  = 1200000,
  parameter int ERR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic [DEV_W-1:0]            dev_sel,
  input  logic                        wide_mode,
  input  logic                        slow_filt,
  input  logic                        sdata_i,
  output logic [NUM_DEV-1:0]          en_o,
  output logic                        sclk_o,
  output logic                        frame_vld,
  output logic [DEV_W-1:0]            frame_dev,
  output logic [NCH_MAX*WORD_W-1:0]   frame_data,
  output logic                        sync_err,
  output logic [ERR_W-1:0]            err_cnt
);
  localparam int FW = NCH_MAX * WORD_W;
  localparam int TW = $clog2(LONG_CYC + 1);
  localparam int CW = $clog2(FW);

  typedef enum logic [2:0] {S_IDLE, S_ENUP, S_SYH, S_SYL, S_BH, S_BL, S_DROP} st_t;

  st_t                             st;
  logic [TW-1:0]                   tmr;
  logic [DEV_W-1:0]                dev_q;
  logic                            wide_q, slow_q, hi_ok, samp_h;
  logic [CW-1:0]                   bcnt;
  logic [FW-2:0]                   sh;
  logic [NCH_MAX-1:0][WORD_W-1:0]  ch_word, frame_q;

  logic            use_slow, tdone, bit_bad;
  logic [TW-1:0]   settle_ld;
  logic [FW-1:0]   sh_nx;
  logic [CW-1:0]   last_bit;

  assign use_slow  = (st == S_IDLE) ? slow_filt : slow_q;
  assign settle_ld = use_slow ? TW'(LONG_CYC - 1) : TW'(SHORT_CYC - 1);
  assign tdone     = (tmr == '0);
  assign sh_nx     = {sh, sdata_i};
  assign last_bit  = wide_q ? CW'(NCH_MAX * WORD_W - 1) : CW'(NCH_MIN * WORD_W - 1);
  assign bit_bad   = (sdata_i != samp_h);

  assign sclk_o     = (st == S_SYH) || (st == S_BH);
  assign en_o       = (st == S_IDLE || st == S_DROP) ? '0 : (NUM_DEV'(1) << dev_q);
  assign frame_dev  = dev_q;
  assign frame_data = frame_q;

  for (genvar k = 0; k < NCH_MAX; k++) begin : g_map
    if (k < NCH_MIN) begin : g_lo
      assign ch_word[k] = wide_q ? sh_nx[(NCH_MAX-1-k)*WORD_W +: WORD_W]
                                 : sh_nx[(NCH_MIN-1-k)*WORD_W +: WORD_W];
    end else begin : g_hi
      assign ch_word[k] = wide_q ? sh_nx[(NCH_MAX-1-k)*WORD_W +: WORD_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      dev_q     <= '0;
      wide_q    <= 1'b0;
      slow_q    <= 1'b0;
      hi_ok     <= 1'b0;
      samp_h    <= 1'b0;
      bcnt      <= '0;
      sh        <= '0;
      frame_q   <= '0;
      frame_vld <= 1'b0;
      sync_err  <= 1'b0;
      err_cnt   <= '0;
    end else begin
      frame_vld <= 1'b0;
      sync_err  <= 1'b0;
      if (st == S_IDLE) begin
        if (run) begin
          dev_q  <= dev_sel;
          wide_q <= wide_mode;
          slow_q <= slow_filt;
          tmr    <= settle_ld;
          st     <= S_ENUP;
        end
      end else if (!tdone) begin
        tmr <= tmr - 1'b1;
      end else begin
        tmr <= settle_ld;
        case (st)
          S_ENUP: st <= run ? S_SYH : S_DROP;
          S_SYH: begin
            hi_ok <= sdata_i;
            st    <= S_SYL;
          end
          S_SYL: begin
            if (hi_ok && !sdata_i) begin
              bcnt <= '0;
              st   <= S_BH;
            end else begin
              st <= run ? S_SYH : S_DROP;
            end
          end
          S_BH: begin
            samp_h <= sdata_i;
            st     <= S_BL;
          end
          S_BL: begin
            if (bit_bad) begin
              sync_err <= 1'b1;
              if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
              st <= S_DROP;
            end else begin
              sh   <= sh_nx[FW-2:0];
              bcnt <= bcnt + 1'b1;
              if (bcnt == last_bit) begin
                frame_vld <= 1'b1;
                frame_q   <= ch_word;
                st        <= run ? S_SYH : S_DROP;
              end else begin
                st <= S_BH;
              end
            end
          end
          S_DROP:  st <= run ? S_ENUP : S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_frame_reader_chk.sv
module sync_frame_reader_chk #(
  parameter int NUM_DEV   = 4,
  parameter int SHORT_CYC = 120000,
  parameter int ERR_W     = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] en_o,
  input logic               sclk_o,
  input logic               frame_vld,
  input logic               sync_err,
  input logic [ERR_W-1:0]   err_cnt
);
  localparam int HW = $clog2(SHORT_CYC + 1) + 1;

  logic          prev_sclk;
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      hold      <= '0;
    end else begin
      prev_sclk <= sclk_o;
      if (sclk_o != prev_sclk) hold <= HW'(1);
      else if (hold < HW'(SHORT_CYC)) hold <= hold + 1'b1;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en_o));

  a_r3_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != prev_sclk) |-> (hold >= HW'(SHORT_CYC)));

  a_r4_en_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o != $past(en_o)) |-> (!sclk_o && !$past(sclk_o)));

  a_r4_clk_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> (en_o != '0));

  a_r8_err_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (en_o == '0));

  a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> ({1'b0, err_cnt} == {1'b0, $past(err_cnt)} + 1'b1));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_cnt) |=> (&err_cnt));

  a_r9_err_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !(&$past(err_cnt))) |-> (err_cnt != $past(err_cnt)));

  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);
endmodule

bind sync_frame_reader sync_frame_reader_chk #(
  .NUM_DEV(NUM_DEV), .SHORT_CYC(SHORT_CYC), .ERR_W(ERR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .en_o(en_o), .sclk_o(sclk_o),
  .frame_vld(frame_vld), .sync_err(sync_err), .err_cnt(err_cnt)
);

// File: tb/test_sync_frame_reader.sv
module test_sync_frame_reader;
  localparam int ND = 4, WW = 16, NMIN = 2, NMAX = 4, SH = 3, LG = 7, EW = 2;
  localparam int FW = NMAX * WW;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, wide_mode = 1'b0, slow_filt = 1'b0;
  logic [1:0] dev_sel = '0;
  logic sdata_i;
  logic [ND-1:0] en_o;
  logic sclk_o, frame_vld, sync_err;
  logic [1:0] frame_dev;
  logic [FW-1:0] frame_data;
  logic [EW-1:0] err_cnt;

  always #5 clk = ~clk;

  sync_frame_reader #(.NUM_DEV(ND), .WORD_W(WW), .NCH_MIN(NMIN), .NCH_MAX(NMAX),
    .SHORT_CYC(SH), .LONG_CYC(LG), .ERR_W(EW)) i_sync_frame_reader (
    .clk(clk), .rst_n(rst_n), .run(run), .dev_sel(dev_sel), .wide_mode(wide_mode),
    .slow_filt(slow_filt), .sdata_i(sdata_i), .en_o(en_o), .sclk_o(sclk_o),
    .frame_vld(frame_vld), .frame_dev(frame_dev), .frame_data(frame_data),
    .sync_err(sync_err), .err_cnt(err_cnt));

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side model of the selected remote unit
  logic [1:0] cur_dev = '0;
  bit cur_wide = 0, cur_slow = 0;
  int mis_off = 0, mis_id = 0, g_pos = 0, g_id = 0, corner_id = 0;
  int mis_used = 0, g_fired = 0, corner_used = 0;
  int pos = 0;
  bit fresh = 0;
  logic dbit = 1'b0, m_en_q = 1'b0, m_clk_q = 1'b0;
  logic [FW-1:0] tx_bits = '0, sent = '0;
  wire my_en = en_o[cur_dev];

  assign sdata_i = (my_en && !fresh) ? ((pos == 0) ? sclk_o : dbit) : 1'b0;

  function automatic logic [FW-1:0] make_frame(bit corner);
    logic [FW-1:0] f = '0;
    for (int k = 0; k < NMAX; k++)
      f[FW-1-k*WW -: WW] = corner ? ((k == 0) ? 16'h8000 : (k == 1) ? 16'h7FFF :
                                     (k == 2) ? 16'hFFFF : 16'h0001)
                                  : WW'($urandom);
    return f;
  endfunction

  function automatic logic [FW-1:0] exp_frame(logic [FW-1:0] bits, bit wide);
    logic [FW-1:0] e = '0;
    for (int k = 0; k < (wide ? NMAX : NMIN); k++) e[k*WW +: WW] = bits[FW-1-k*WW -: WW];
    return e;
  endfunction

  always @(sclk_o or my_en) begin
    int nb;
    nb = cur_wide ? NMAX*WW : NMIN*WW;
    if (my_en && !m_en_q) fresh = 1;
    if (my_en && sclk_o && !m_clk_q) begin
      if (fresh) begin
        fresh = 0;
        pos = (mis_id != mis_used) ? mis_off : 0;
        mis_used = mis_id;
      end else begin
        pos = (pos >= nb) ? 0 : pos + 1;
      end
      if (pos == 0) begin
        tx_bits = make_frame(corner_id != corner_used);
        corner_used = corner_id;
      end else begin
        dbit = tx_bits[FW-pos];
        if (pos == nb) sent = tx_bits;
      end
    end
    if (my_en && !sclk_o && m_clk_q && pos != 0 && pos == g_pos && g_id != g_fired) begin
      dbit = ~dbit;
      g_fired = g_id;
    end
    m_en_q = my_en;
    m_clk_q = sclk_o;
  end

  // output monitor, sampled away from the active edge
  int vld_cnt = 0, err_seen = 0, hi_len = 0;
  logic [ND-1:0] en_prev = '0;
  logic sclk_prev = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (frame_vld) begin
      vld_cnt++;
      chk(frame_data == exp_frame(sent, cur_wide), "R6 R7 R10 frame words", frame_data,
          exp_frame(sent, cur_wide));
      chk(frame_dev == cur_dev, "R10 frame device", FW'(frame_dev), FW'(cur_dev));
    end
    if (sync_err) begin
      err_seen++;
      chk(en_o == '0, "R8 enable low on error", FW'(en_o), '0);
    end
    if (en_o != en_prev) begin
      chk(!sclk_o && !sclk_prev, "R4 enable moves with clock low", FW'(sclk_o), '0);
      chk(en_o == '0 || en_o == (ND'(1) << cur_dev), "R2 one-hot enable", FW'(en_o),
          FW'(ND'(1) << cur_dev));
    end
    if (sclk_o) hi_len++;
    else begin
      if (sclk_prev) chk(hi_len == (cur_slow ? LG : SH), "R3 clock high hold",
                         FW'(hi_len), FW'(cur_slow ? LG : SH));
      hi_len = 0;
    end
    en_prev = en_o;
    sclk_prev = sclk_o;
  end

  task automatic start_run(logic [1:0] d, bit w, bit s);
    cur_dev = d; cur_wide = w; cur_slow = s;
    dev_sel = d; wide_mode = w; slow_filt = s;
    run = 1'b1;
  endtask

  task automatic wait_frames(int n);
    int tgt;
    tgt = vld_cnt + n;
    while (vld_cnt < tgt) @(negedge clk);
  endtask

  task automatic stop_run();
    int base;
    run = 1'b0;
    base = vld_cnt;
    while (en_o != '0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(en_o == '0 && !sclk_o, "R11 idle after stop", FW'({en_o, sclk_o}), '0);
    chk(vld_cnt - base <= 1, "R11 at most one frame after stop", FW'(vld_cnt - base), 1);
  endtask

  task automatic glitch(int p);
    int tgt;
    tgt = err_seen + 1;
    g_pos = p;
    g_id++;
    while (err_seen < tgt) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [EW-1:0] e0;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(en_o == '0 && !sclk_o && !frame_vld && !sync_err && err_cnt == '0,
        "R1 reset state", FW'({en_o, sclk_o, frame_vld, sync_err, err_cnt}), '0);

    // R6: extreme words, two channels, short settle
    corner_id++;
    start_run(2'd1, 1'b0, 1'b0);
    wait_frames(3);
    stop_run();

    // R6 R3: four channels, long settle, extreme words first
    corner_id++;
    start_run(2'd3, 1'b1, 1'b1);
    wait_frames(2);
    stop_run();

    // R5: unit starts mid-frame, reader must resync without error
    e0 = err_cnt;
    mis_off = 7; mis_id++;
    start_run(2'd0, 1'b0, 1'b0);
    wait_frames(2);
    chk(err_cnt == e0, "R5 resync counts no error", FW'(err_cnt), FW'(e0));
    stop_run();

    // R8: unstable bit aborts and restarts
    start_run(2'd2, 1'b0, 1'b0);
    wait_frames(1);
    glitch(10);
    chk(err_cnt == EW'(1), "R8 error counted", FW'(err_cnt), 1);
    wait_frames(1);
    // R9: drive the counter into saturation
    for (int i = 0; i < 4; i++) begin
      glitch(1 + i * 7);
      wait_frames(1);
    end
    chk(err_cnt == '1, "R9 counter saturates", FW'(err_cnt), FW'({EW{1'b1}}));
    chk(err_seen == 5, "R8 one pulse per unstable bit", FW'(err_seen), 5);
    stop_run();

    // random rounds
    for (int r = 0; r < 6; r++) begin
      logic [1:0] d;
      bit w, s;
      d = 2'($urandom % ND);
      w = 1'($urandom);
      s = 1'($urandom);
      if ($urandom % 2 == 1) begin
        mis_off = 1 + int'($urandom % 30);
        mis_id++;
      end
      start_run(d, w, s);
      wait_frames(1 + int'($urandom % 2));
      stop_run();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule